// File: doc/BRIEF.md
# Change-Detection Interrupt Unit

This unit watches a bank of 8-bit digital input ports and raises a level interrupt when chosen inputs change. Every input bit has its own pair of enables, one for low-to-high and one for high-to-low transitions, and a global control byte can switch detection, each direction, overflow tracking and the interrupt on or off. Inputs are brought into the clock domain through a two-flop synchronizer. A transition is detected by comparing the synchronized sample with the sample one cycle older.

The first qualifying transition latches an event flag and the direction it came from. It also freezes a snapshot of all synchronized port inputs. A further qualifying transition that arrives while the event is still unacknowledged is recorded as an overflow. Software reads a status byte and acknowledges through a write-one-to-clear byte. Everything is reached through a simple byte-wide register interface with a write strobe and a combinational read path.

Top module: `chgdet_top`

## Requirements
- R1: After a synchronous active-low reset, control, masks, status and snapshot are all zero and `irq` is low.
- R2: Address 0x00 reads the constant `ID_VALUE` (default 0xA5). Control (0x03) and the per-port mask bytes read back what was written. Port p has its registers at 0x40 + 0x10·p: rise mask at +2 and fall mask at +3.
- R3: A low-to-high change of input bit b of port p sets status bit0 (event) on the third rising clock edge after the change. This happens only when rise-mask bit b, control bit3 (rising allowed) and control bit0 (detect on) are all set.
- R4: A high-to-low change is detected in the same way, using the fall mask and control bit4 (falling allowed).
- R5: Status bit3 records that a rising change was seen and status bit4 that a falling change was seen. Both stay set until the event is cleared.
- R6: A qualifying change that arrives while the event is already pending sets status bit1 (overflow), but only when control bit1 is set.
- R7: `irq` equals control bit2 AND (event OR (overflow AND control bit1)). Status bit2 reads the same value.
- R8: Writing to 0x01 clears state: bit3 clears the event and both direction flags, and bit2 clears the overflow. Other bits have no effect.
- R9: `snap_out` captures all synchronized inputs at the first qualifying change. It holds that value while the event stays pending.
- R10: If a clear of the event and a new qualifying change fall in the same cycle, the change wins. The event stays set, the snapshot is retaken and no overflow is recorded.
- R11: With control written to 0x00, no input change sets any status bit and `irq` stays low.
- R12: Offset +0 of each port reads that port's synchronized input byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pins_in | input | 8·NPORT | Asynchronous digital inputs, port p in bits 8p+7..8p |
| irq | output | 1 | Level interrupt request |
| snap_out | output | 8·NPORT | Input snapshot taken at the first qualifying change |

## Verification
An acknowledge write to the clear byte and a newly detected change can land on the same clock edge. The bench provokes this by changing an input pin, then timing the clear write so that it is sampled on exactly the third edge after the change, which is the edge where detection completes. The outcome is judged at the ports: the event must remain set with the rising flag, the overflow bit must stay clear, and the snapshot must show the new pin value. This is contrasted with a later change that arrives without a clear, which must raise the overflow bit.

// File: rtl/chgdet_pkg.sv
// Shared constants and types for the change-detection interrupt unit.
// Assumes an 8-bit register address space with per-port blocks at a fixed stride.
package chgdet_pkg;

    localparam int PORT_W = 8;

    // Global register addresses
    localparam logic [7:0] A_ID   = 8'h00;
    localparam logic [7:0] A_CLR  = 8'h01;
    localparam logic [7:0] A_STAT = 8'h02;
    localparam logic [7:0] A_CTRL = 8'h03;

    // Per-port register block layout
    localparam int PORT_BASE   = 'h40;
    localparam int PORT_STRIDE = 'h10;
    localparam int OFS_DATA    = 0;
    localparam int OFS_RISE    = 2;
    localparam int OFS_FALL    = 3;

    // Clear register bit positions
    localparam int CLR_EVT_BIT = 3;
    localparam int CLR_OVF_BIT = 2;

    // Control byte, bit4 down to bit0
    typedef struct packed {
        logic fall_on;   // bit4
        logic rise_on;   // bit3
        logic irq_on;    // bit2
        logic ovf_on;    // bit1
        logic det_on;    // bit0
    } ctrl_t;

endpackage

// File: rtl/chgdet_sync.sv
// Two-flop synchronizer followed by a history flop.
// cur is the synchronized sample; prev is the same sample one cycle older.
module chgdet_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] hist_q;

    // Purpose: resynchronize inputs and keep one cycle of history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign cur  = sync_q;
    assign prev = hist_q;

endmodule

// File: rtl/chgdet_edge.sv
// Per-port transition qualifier: compares the current and previous samples
// and keeps only the transitions allowed by the bit masks and global direction gates.
// Purely combinational.
module chgdet_edge #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] rise_mask,
    input  logic [W-1:0] fall_mask,
    input  logic         rise_on,
    input  logic         fall_on,
    output logic         rise_any,
    output logic         fall_any
);

    logic [W-1:0] changed;
    logic [W-1:0] rise_v;
    logic [W-1:0] fall_v;

    // Purpose: split changed bits by direction and apply the enables
    always_comb begin
        changed  = cur ^ prev;
        rise_v   = changed & cur  & rise_mask & {W{rise_on}};
        fall_v   = changed & prev & fall_mask & {W{fall_on}};
        rise_any = |rise_v;
        fall_any = |fall_v;
    end

endmodule

// File: rtl/chgdet_event.sv
// Event, direction, overflow and snapshot latches.
// Assumes the clear strobes are single-cycle. A new hit in the clear cycle wins over the clear.
module chgdet_event #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_any,
    input  logic          fall_any,
    input  logic          det_on,
    input  logic          ovf_on,
    input  logic          clr_evt,
    input  logic          clr_ovf,
    input  logic [DW-1:0] sample,
    output logic          hit,
    output logic          evt,
    output logic          ovf,
    output logic          rise_seen,
    output logic          fall_seen,
    output logic [DW-1:0] snap
);

    logic evt_held;

    // Purpose: qualify a hit and find whether an event survives this cycle
    always_comb begin
        hit      = det_on & (rise_any | fall_any);
        evt_held = evt & ~clr_evt;
    end

    // Purpose: update the latched event state and the input snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt       <= 1'b0;
            ovf       <= 1'b0;
            rise_seen <= 1'b0;
            fall_seen <= 1'b0;
            snap      <= '0;
        end else begin
            evt       <= hit | evt_held;
            ovf       <= (ovf & ~clr_ovf) | (hit & evt_held & ovf_on);
            rise_seen <= (rise_seen & ~clr_evt) | (hit & rise_any);
            fall_seen <= (fall_seen & ~clr_evt) | (hit & fall_any);
            if (hit && !evt_held) begin
                snap <= sample;
            end
        end
    end

endmodule

// File: rtl/chgdet_top.sv
// Change-detection interrupt unit: byte register interface, per-port masks,
// synchronizer, qualifiers and event latches. Assumes NPORT <= 12 so all
// port blocks fit below address 0x100.
module chgdet_top #(
    parameter int         NPORT    = 2,
    parameter logic [7:0] ID_VALUE = 8'hA5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_we,
    input  logic [7:0]                      bus_addr,
    input  logic [7:0]                      bus_wdata,
    output logic [7:0]                      bus_rdata,
    input  logic [NPORT*chgdet_pkg::PORT_W-1:0] pins_in,
    output logic                            irq,
    output logic [NPORT*chgdet_pkg::PORT_W-1:0] snap_out
);
    import chgdet_pkg::*;

    localparam int DW = NPORT * PORT_W;

    ctrl_t             ctrl_q;
    logic [PORT_W-1:0] rmask_q [NPORT];
    logic [PORT_W-1:0] fmask_q [NPORT];
    logic [DW-1:0]     cur;
    logic [DW-1:0]     prev;
    logic [NPORT-1:0]  rise_p;
    logic [NPORT-1:0]  fall_p;
    logic              rise_any;
    logic              fall_any;
    logic              clr_evt;
    logic              clr_ovf;
    logic              hit;
    logic              evt;
    logic              ovf;
    logic              rise_seen;
    logic              fall_seen;
    logic [7:0]        status;

    // Purpose: decode the write-one-to-clear strobes
    always_comb begin
        clr_evt = bus_we && (bus_addr == A_CLR) && bus_wdata[CLR_EVT_BIT];
        clr_ovf = bus_we && (bus_addr == A_CLR) && bus_wdata[CLR_OVF_BIT];
    end

    // Purpose: hold the global control byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_we && bus_addr == A_CTRL) begin
            ctrl_q <= ctrl_t'(bus_wdata[4:0]);
        end
    end

    chgdet_sync #(.WIDTH(DW)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pins_in),
        .cur  (cur),
        .prev (prev)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam logic [7:0] A_RISE_P = 8'(PORT_BASE + p * PORT_STRIDE + OFS_RISE);
        localparam logic [7:0] A_FALL_P = 8'(PORT_BASE + p * PORT_STRIDE + OFS_FALL);

        // Purpose: hold this port's rise and fall mask bytes
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rmask_q[p] <= '0;
                fmask_q[p] <= '0;
            end else if (bus_we) begin
                if (bus_addr == A_RISE_P) rmask_q[p] <= bus_wdata;
                if (bus_addr == A_FALL_P) fmask_q[p] <= bus_wdata;
            end
        end

        chgdet_edge #(.W(PORT_W)) u_edge (
            .cur      (cur[p*PORT_W +: PORT_W]),
            .prev     (prev[p*PORT_W +: PORT_W]),
            .rise_mask(rmask_q[p]),
            .fall_mask(fmask_q[p]),
            .rise_on  (ctrl_q.rise_on),
            .fall_on  (ctrl_q.fall_on),
            .rise_any (rise_p[p]),
            .fall_any (fall_p[p])
        );
    end

    // Purpose: merge per-port qualifier results
    always_comb begin
        rise_any = |rise_p;
        fall_any = |fall_p;
    end

    chgdet_event #(.DW(DW)) u_event (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_any (rise_any),
        .fall_any (fall_any),
        .det_on   (ctrl_q.det_on),
        .ovf_on   (ctrl_q.ovf_on),
        .clr_evt  (clr_evt),
        .clr_ovf  (clr_ovf),
        .sample   (cur),
        .hit      (hit),
        .evt      (evt),
        .ovf      (ovf),
        .rise_seen(rise_seen),
        .fall_seen(fall_seen),
        .snap     (snap_out)
    );

    // Purpose: form the interrupt level and the status byte
    always_comb begin
        irq    = ctrl_q.irq_on & (evt | (ovf & ctrl_q.ovf_on));
        status = {3'b000, fall_seen, rise_seen, irq, ovf, evt};
    end

    // Purpose: combinational read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_ID:    bus_rdata = ID_VALUE;
            A_STAT:  bus_rdata = status;
            A_CTRL:  bus_rdata = {3'b000, ctrl_q};
            default: bus_rdata = '0;
        endcase
        for (int p = 0; p < NPORT; p++) begin
            if (bus_addr == 8'(PORT_BASE + p * PORT_STRIDE + OFS_DATA))
                bus_rdata = cur[p*PORT_W +: PORT_W];
            if (bus_addr == 8'(PORT_BASE + p * PORT_STRIDE + OFS_RISE))
                bus_rdata = rmask_q[p];
            if (bus_addr == 8'(PORT_BASE + p * PORT_STRIDE + OFS_FALL))
                bus_rdata = fmask_q[p];
        end
    end

endmodule

// File: rtl/chgdet_chk.sv
// Property checker for chgdet_top, attached by bind to internal nets.
module chgdet_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic [7:0]    bus_addr,
    input logic [7:0]    bus_wdata,
    input logic          hit,
    input logic          evt,
    input logic          ovf,
    input logic [4:0]    ctrl,
    input logic          irq,
    input logic [DW-1:0] snap
);

    logic clr_evt_wr;
    assign clr_evt_wr = bus_we && (bus_addr == 8'h01) && bus_wdata[3];

    p_hit_sets_evt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> evt);

    p_ovf_needs_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(evt));

    p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl[2]);

    p_clear_drops_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt_wr && !hit) |=> !evt);

    p_snap_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !clr_evt_wr) |=> $stable(snap));

    p_collide_keeps_evt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && clr_evt_wr && !ovf) |=> (evt && !ovf));

    p_off_no_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[0] && !evt) |=> !evt);

endmodule

bind chgdet_top chgdet_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .hit      (hit),
    .evt      (evt),
    .ovf      (ovf),
    .ctrl     (ctrl_q),
    .irq      (irq),
    .snap     (snap_out)
);

// File: tb/test_chgdet_top.sv
`timescale 1ns/100ps
module test_chgdet_top;

    localparam int NPORT = 2;
    localparam int DW    = NPORT * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [DW-1:0] pins = '0;
    logic          irq;
    logic [DW-1:0] snap;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    chgdet_top #(.NPORT(NPORT), .ID_VALUE(8'hA5)) i_chgdet_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pins_in  (pins),
        .irq      (irq),
        .snap_out (snap)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        step();
        d = bus_rdata;
    endtask

    function automatic logic [7:0] a_rise(input int p); return 8'('h40 + 'h10*p + 2); endfunction
    function automatic logic [7:0] a_fall(input int p); return 8'('h40 + 'h10*p + 3); endfunction
    function automatic logic [7:0] a_data(input int p); return 8'('h40 + 'h10*p); endfunction

    task automatic settle();
        step(); step(); step();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        logic [7:0] r;
        step(); step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 snap", snap, 0);
        rd(8'h02, r); check("R1 status", r, 8'h00);
        rd(8'h03, r); check("R1 ctrl", r, 8'h00);
        rd(a_rise(1), r); check("R1 rise mask", r, 8'h00);

        // R2 identification and readback
        rd(8'h00, r); check("R2 id", r, 8'hA5);
        wr(a_rise(1), 8'h5A); rd(a_rise(1), r); check("R2 rise mask", r, 8'h5A);
        wr(a_fall(1), 8'hC3); rd(a_fall(1), r); check("R2 fall mask", r, 8'hC3);
        wr(a_rise(1), 8'h00); wr(a_fall(1), 8'h00);

        // R3 R4 R5 R7 R9 R12 sweep of every port, bit and mask combination
        wr(8'h03, 8'h1F);
        for (int p = 0; p < NPORT; p++) begin
            for (int b = 0; b < 8; b++) begin
                for (int m = 0; m < 4; m++) begin
                    logic hr, hf;
                    hr = m[0]; hf = m[1];
                    wr(a_rise(p), hr ? 8'(1 << b) : 8'h00);
                    wr(a_fall(p), hf ? 8'(1 << b) : 8'h00);
                    pins[p*8 + b] = 1'b1;
                    settle();
                    check("R3 R7 irq on rise", irq, hr);
                    if (hr) check("R9 snap on rise", snap, pins);
                    rd(8'h02, r); check("R3 R5 status rise", r, hr ? 8'h0D : 8'h00);
                    rd(a_data(p), r); check("R12 data", r, pins[p*8 +: 8]);
                    wr(8'h01, 8'h0C);
                    rd(8'h02, r); check("R8 cleared", r, 8'h00);
                    pins[p*8 + b] = 1'b0;
                    settle();
                    check("R4 R7 irq on fall", irq, hf);
                    if (hf) check("R9 snap on fall", snap, pins);
                    rd(8'h02, r); check("R4 R5 status fall", r, hf ? 8'h15 : 8'h00);
                    wr(8'h01, 8'h0C);
                end
            end
            wr(a_rise(p), 8'h00); wr(a_fall(p), 8'h00);
        end

        // R6 overflow, R8 selective clearing, R9 snapshot hold
        wr(a_rise(0), 8'hFF);
        pins[0] = 1'b1; settle();
        check("R9 first snap", snap, 16'h0001);
        pins[1] = 1'b1; settle();
        rd(8'h02, r); check("R6 overflow set", r, 8'h0F);
        check("R9 snap held", snap, 16'h0001);
        wr(8'h01, 8'hF3);
        rd(8'h02, r); check("R8 non-clear bits ignored", r, 8'h0F);
        wr(8'h01, 8'h04);
        rd(8'h02, r); check("R8 clear overflow only", r, 8'h0D);

        // R10 clear of the event in the same cycle as a new change
        pins[2] = 1'b1;
        step(); step();
        bus_we = 1'b1; bus_addr = 8'h01; bus_wdata = 8'h08;
        step();
        bus_we = 1'b0;
        rd(8'h02, r); check("R10 event kept, no overflow", r, 8'h0D);
        check("R10 snap retaken", snap, 16'h0007);
        pins[3] = 1'b1; settle();
        rd(8'h02, r); check("R6 overflow after pending", r, 8'h0F);

        // R7 overflow alone drives irq only while overflow enabled
        wr(8'h01, 8'h08);
        check("R7 irq from overflow", irq, 1);
        rd(8'h02, r); check("R7 status overflow only", r, 8'h06);
        wr(8'h03, 8'h1D);
        check("R7 irq overflow gated", irq, 0);
        rd(8'h02, r); check("R7 status bit2 low", r, 8'h02);
        wr(8'h01, 8'h04);

        // R6 no overflow when disabled
        pins[4] = 1'b1; settle();
        pins[5] = 1'b1; settle();
        rd(8'h02, r); check("R6 overflow disabled", r, 8'h0D);
        wr(8'h01, 8'h0C);

        // R7 interrupt enable off, then on while pending
        wr(8'h03, 8'h19);
        pins[6] = 1'b1; settle();
        check("R7 irq disabled", irq, 0);
        rd(8'h02, r); check("R7 status no irq", r, 8'h09);
        wr(8'h03, 8'h1D);
        check("R7 irq after enable", irq, 1);
        wr(8'h01, 8'h0C);

        // R4 global falling gate off
        wr(a_fall(0), 8'hFF);
        wr(8'h03, 8'h0D);
        pins[7:0] = 8'h00; settle();
        rd(8'h02, r); check("R4 falling gated off", r, 8'h00);

        // R11 everything off
        wr(8'h03, 8'h00);
        wr(a_rise(1), 8'hFF); wr(a_fall(1), 8'hFF);
        pins = 16'hA5FF; settle();
        pins = 16'h0000; settle();
        check("R11 irq off", irq, 0);
        rd(8'h02, r); check("R11 status off", r, 8'h00);

        done = 1'b1;
        summary();
    end

endmodule